// File: doc/BRIEF.md
# Stereo Volume Stage with Soft Mute

This block sits in a DAC sample path and scales each stereo sample pair by a gain that is the product of two factors. The first is a dB-linear volume setting, from 0 dB down to -60 dB in 1 dB steps, plus codes that cut the signal to silence. The second is a soft-mute factor that moves along a raised-cosine curve, so a mute or unmute is heard as a short fade and not as a click.

A mute can be requested from an external pin or from a control bit. By default the stage also mutes by itself whenever the upstream input decoder reports loss of lock. An override bit turns that automatic mute off. The fade position advances once per sample strobe. If the request changes halfway through a fade, the fade turns around from where it is, with no jump. Both channels use the same gain on every strobe, and the scaled pair is registered one cycle after the strobe.

Top module: `sm_volume`

## Requirements
- R1: Volume code 0 with the fade at rest passes each sample unchanged. Codes 1 to 60 scale the sample by 10^(-code/20), and the result is within 2 + |x|/8192 LSB of the ideal value.
- R2: Volume codes 61 to 63 give an output of exactly 0 on both channels.
- R3: While a mute request is held, the k-th strobe after the request (counting from k = 0) is scaled by 0.5*(1+cos(pi*min(k,32)/32)). From the 33rd strobe on, the output is exactly 0.
- R4: The mute pin alone, or the mute control bit alone, starts the fade of R3.
- R5: With the override bit at 0, lock_ok at 0 acts as a mute request. With the override bit at 1, the state of lock_ok has no effect on the output.
- R6: When the request is released after a full mute, the k-th strobe after the release is scaled by 0.5*(1+cos(pi*max(32-k,0)/32)). Full gain returns on the 33rd strobe.
- R7: A change of request during a fade reverses the direction from the present fade position. The position moves by exactly one step per strobe and never jumps.
- R8: Each product is rounded half-up to 20 bits and clamped to the signed 20-bit range. The magnitude of an output sample never exceeds the magnitude of its input, including at -524288 and +524287.
- R9: out_valid pulses high exactly one cycle after each strobe, and out_l and out_r change only in that cycle. Between strobes the outputs and the fade position hold.
- R10: After reset, out_valid, out_l and out_r are 0 and the fade is at full gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe, one cycle per stereo pair |
| smp_l | input | 20 | Left input sample, two's complement |
| smp_r | input | 20 | Right input sample, two's complement |
| vol_code | input | 6 | Attenuation in dB; 61 to 63 cut the output |
| mute_pin | input | 1 | External mute request |
| mute_bit | input | 1 | Register mute request |
| lock_ok | input | 1 | Qualified decoder lock flag |
| lock_mute_off | input | 1 | 1 disables the automatic mute on loss of lock |
| out_valid | output | 1 | Output strobe, one cycle after smp_valid |
| out_l | output | 20 | Scaled left sample |
| out_r | output | 20 | Scaled right sample |

## Verification
The assertions assume that smp_valid is a single-cycle pulse and that the volume and mute inputs are stable on the strobe cycle. They also assume each input sample is a legal 20-bit value, so an output magnitude can be compared with the input magnitude. The bench drives every input at the falling edge. It raises the strobe for one cycle with at least one idle cycle after it, and it changes the mute, lock and volume inputs only between strobes. The bench tracks the fade position with its own model and computes each expected value from real-valued gain formulas.

// File: rtl/vol_pkg.sv
package vol_pkg;

    localparam int SAMPLE_W = 20;
    localparam int VOL_W    = 6;
    localparam int FRAC     = 16;
    localparam int COEF_W   = FRAC + 1;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [COEF_W-1:0]          coef_t;

    typedef struct packed {
        sample_t l;
        sample_t r;
    } stereo_t;

    typedef enum logic [1:0] {
        RAMP_HOLD,
        RAMP_DOWN,
        RAMP_UP
    } ramp_dir_e;

    localparam coef_t UNITY = coef_t'(1 << FRAC);

    // Q1.16 gain for an attenuation of code dB, built at elaboration.
    function automatic coef_t db_coef(input int code);
        real g;
        g = $pow(10.0, -real'(code) / 20.0);
        return coef_t'($rtoi(g * real'(1 << FRAC) + 0.5));
    endfunction

    // Q1.16 raised-cosine factor at step p of a len-step fade.
    function automatic coef_t cos_coef(input int p, input int len);
        real c;
        c = 0.5 * (1.0 + $cos(3.14159265358979 * real'(p) / real'(len)));
        return coef_t'($rtoi(c * real'(1 << FRAC) + 0.5));
    endfunction

    // Product of two Q1.16 gains, rounded back to Q1.16.
    function automatic coef_t mix_gain(input coef_t a, input coef_t b);
        logic [2*COEF_W:0] p;
        p = {1'b0, a} * {1'b0, b} + (2*COEF_W+1)'(1 << (FRAC - 1));
        return p[FRAC +: COEF_W];
    endfunction

    // Scales a sample by a Q1.16 gain with half-up rounding and clamping.
    function automatic sample_t scale_sat(input sample_t x, input coef_t g);
        logic signed [SAMPLE_W+COEF_W:0]   p;
        logic signed [SAMPLE_W+COEF_W:0]   r;
        logic signed [SAMPLE_W+COEF_W-FRAC:0] q;
        p = x * $signed({1'b0, g});
        r = p + (SAMPLE_W+COEF_W+1)'(1 << (FRAC - 1));
        q = r[SAMPLE_W+COEF_W:FRAC];
        if (q > $signed((SAMPLE_W+COEF_W-FRAC+1)'((1 << (SAMPLE_W-1)) - 1)))
            return sample_t'((1 << (SAMPLE_W-1)) - 1);
        else if (q < -$signed((SAMPLE_W+COEF_W-FRAC+1)'(1 << (SAMPLE_W-1))))
            return sample_t'(1 << (SAMPLE_W-1));
        else
            return q[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom
    import vol_pkg::*;
#(
    parameter int MAX_DB = 60
) (
    input  logic [VOL_W-1:0] code,
    output coef_t            gain
);
    localparam int ENTRIES = 1 << VOL_W;

    coef_t tab [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_tab
        if (i <= MAX_DB) begin : g_step
            assign tab[i] = db_coef(i);
        end else begin : g_cut
            assign tab[i] = '0;
        end
    end

    assign gain = tab[code];
endmodule

// File: rtl/mute_ramp.sv
module mute_ramp
    import vol_pkg::*;
#(
    parameter int RAMP_LEN = 32,
    localparam int POS_W = $clog2(RAMP_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             mute_req,
    output logic [POS_W-1:0] pos,
    output coef_t            fade_gain
);
    localparam int ENTRIES = 1 << POS_W;
    localparam logic [POS_W-1:0] LAST = POS_W'(RAMP_LEN);

    coef_t     tab [ENTRIES];
    ramp_dir_e dir;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_tab
        if (i <= RAMP_LEN) begin : g_pt
            assign tab[i] = cos_coef(i, RAMP_LEN);
        end else begin : g_pad
            assign tab[i] = '0;
        end
    end

    always_comb begin
        if (mute_req && pos != LAST)
            dir = RAMP_DOWN;
        else if (!mute_req && pos != '0)
            dir = RAMP_UP;
        else
            dir = RAMP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (step) begin
            case (dir)
                RAMP_DOWN: pos <= pos + 1'b1;
                RAMP_UP:   pos <= pos - 1'b1;
                default:   pos <= pos;
            endcase
        end
    end

    assign fade_gain = tab[pos];
endmodule

// File: rtl/gain_apply.sv
module gain_apply
    import vol_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input  coef_t   vol_gain,
    input  coef_t   fade_gain,
    input  sample_t din  [CHANNELS],
    output sample_t dout [CHANNELS]
);
    coef_t g;

    assign g = mix_gain(vol_gain, fade_gain);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        assign dout[c] = scale_sat(din[c], g);
    end
endmodule

// File: rtl/sm_volume.sv
module sm_volume
    import vol_pkg::*;
#(
    parameter int MAX_DB   = 60,
    parameter int RAMP_LEN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_l,
    input  logic [SAMPLE_W-1:0] smp_r,
    input  logic [VOL_W-1:0]    vol_code,
    input  logic                mute_pin,
    input  logic                mute_bit,
    input  logic                lock_ok,
    input  logic                lock_mute_off,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_l,
    output logic [SAMPLE_W-1:0] out_r
);
    localparam int POS_W = $clog2(RAMP_LEN + 1);

    logic             mute_req;
    logic [POS_W-1:0] ramp_pos;
    coef_t            vol_gain;
    coef_t            fade_gain;
    sample_t          din  [2];
    sample_t          dout [2];
    stereo_t          q;

    assign mute_req = mute_pin | mute_bit | (~lock_ok & ~lock_mute_off);

    vol_gain_rom #(.MAX_DB(MAX_DB)) u_rom (
        .code (vol_code),
        .gain (vol_gain)
    );

    mute_ramp #(.RAMP_LEN(RAMP_LEN)) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .step      (smp_valid),
        .mute_req  (mute_req),
        .pos       (ramp_pos),
        .fade_gain (fade_gain)
    );

    assign din[0] = smp_l;
    assign din[1] = smp_r;

    gain_apply #(.CHANNELS(2)) u_apply (
        .vol_gain  (vol_gain),
        .fade_gain (fade_gain),
        .din       (din),
        .dout      (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                q.l <= dout[0];
                q.r <= dout[1];
            end
        end
    end

    assign out_l = q.l;
    assign out_r = q.r;
endmodule

// File: rtl/sm_volume_checker.sv
module sm_volume_checker
    import vol_pkg::*;
#(
    parameter int MAX_DB   = 60,
    parameter int RAMP_LEN = 32,
    localparam int POS_W   = $clog2(RAMP_LEN + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_l,
    input logic [VOL_W-1:0]    vol_code,
    input logic                mute_req,
    input logic [POS_W-1:0]    ramp_pos,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_l,
    input logic [SAMPLE_W-1:0] out_r
);
    localparam logic [VOL_W-1:0] LAST_CODE = VOL_W'(MAX_DB);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(RAMP_LEN);

    function automatic logic [SAMPLE_W:0] mag(input logic [SAMPLE_W-1:0] v);
        logic signed [SAMPLE_W:0] e;
        e = $signed({v[SAMPLE_W-1], v});
        return (e < 0) ? (SAMPLE_W+1)'(-e) : (SAMPLE_W+1)'(e);
    endfunction

    // R2
    p_cut_zero_r2: assert property (@(posedge clk) disable iff (rst)
        smp_valid && vol_code > LAST_CODE |=> out_l == '0 && out_r == '0);

    // R3
    p_fade_down_r3: assert property (@(posedge clk) disable iff (rst)
        smp_valid && mute_req && ramp_pos != LAST_POS |=> ramp_pos == $past(ramp_pos) + 1'b1);

    p_silent_r3: assert property (@(posedge clk) disable iff (rst)
        smp_valid && ramp_pos == LAST_POS |=> out_l == '0 && out_r == '0);

    // R6
    p_fade_up_r6: assert property (@(posedge clk) disable iff (rst)
        smp_valid && !mute_req && ramp_pos != '0 |=> ramp_pos == $past(ramp_pos) - 1'b1);

    // R7
    p_pos_range_r7: assert property (@(posedge clk) disable iff (rst)
        ramp_pos <= LAST_POS);

    // R8
    p_no_growth_r8: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> mag(out_l) <= mag($past(smp_l)));

    // R9
    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !out_valid && $stable(out_l) && $stable(out_r) && $stable(ramp_pos));
endmodule

bind sm_volume sm_volume_checker #(.MAX_DB(MAX_DB), .RAMP_LEN(RAMP_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_l     (smp_l),
    .vol_code  (vol_code),
    .mute_req  (mute_req),
    .ramp_pos  (ramp_pos),
    .out_valid (out_valid),
    .out_l     (out_l),
    .out_r     (out_r)
);

// File: tb/test_sm_volume.sv
module test_sm_volume;
    logic        clk = 0;
    logic        rst = 1;
    logic        smp_valid = 0;
    logic [19:0] smp_l = '0, smp_r = '0;
    logic [5:0]  vol_code = '0;
    logic        mute_pin = 0, mute_bit = 0, lock_ok = 1, lock_mute_off = 0;
    logic        out_valid;
    logic [19:0] out_l, out_r;

    int checks = 0;
    int errors = 0;
    int pos    = 0;   // bench model of the fade position

    always #5 clk = ~clk;

    sm_volume i_sm_volume (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
        .vol_code(vol_code), .mute_pin(mute_pin), .mute_bit(mute_bit),
        .lock_ok(lock_ok), .lock_mute_off(lock_mute_off),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    // vol(6) | left(20) | right(20)
    localparam int NV = 10;
    localparam logic [45:0] VEC [NV] = '{
        {6'd0,  20'sd1000,    -20'sd1000},
        {6'd0,  20'sd524287,  -20'sd524288},
        {6'd1,  20'sd300000,  -20'sd300000},
        {6'd6,  20'sd1,       20'sd123457},
        {6'd20, 20'sd400000,  -20'sd77777},
        {6'd33, -20'sd250000, 20'sd99999},
        {6'd60, 20'sd524287,  -20'sd524288},
        {6'd61, 20'sd500000,  -20'sd500000},
        {6'd63, -20'sd1,      20'sd1},
        {6'd59, 20'sd0,       20'sd262144}
    };

    task automatic report(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic real model_gain(input int v, input int p);
        real vg;
        vg = (v > 60) ? 0.0 : $pow(10.0, -real'(v) / 20.0);
        return vg * 0.5 * (1.0 + $cos(3.14159265358979 * real'(p) / 32.0));
    endfunction

    task automatic cmp(input string tag, input int act, input int x, input int v, input int p);
        real e, d, tol;
        int  ei;
        e = real'(x) * model_gain(v, p);
        ei = $rtoi(e + ((e < 0.0) ? -0.5 : 0.5));
        if (v > 60 || p == 32)
            report(tag, act == 0, act, 0);
        else if (v == 0 && p == 0)
            report(tag, act == x, act, x);
        else begin
            d = real'(act) - e;
            if (d < 0.0) d = -d;
            tol = 2.0 + real'((x < 0) ? -x : x) / 8192.0;
            report(tag, d <= tol, act, ei);
        end
    endtask

    task automatic sample(input string tag, input int l, input int r);
        bit req;
        @(negedge clk);
        smp_valid = 1;
        smp_l = 20'(l);
        smp_r = 20'(r);
        @(negedge clk);
        smp_valid = 0;
        report({tag, " valid"}, out_valid == 1'b1, int'(out_valid), 1);
        cmp({tag, " left"},  int'($signed(out_l)), l, int'(vol_code), pos);
        cmp({tag, " right"}, int'($signed(out_r)), r, int'(vol_code), pos);
        req = mute_pin | mute_bit | (!lock_ok && !lock_mute_off);
        if (req && pos < 32) pos++;
        else if (!req && pos > 0) pos--;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        report("R10 valid", out_valid == 0, int'(out_valid), 0);
        report("R10 left", out_l == 0, int'($signed(out_l)), 0);
        report("R10 right", out_r == 0, int'($signed(out_r)), 0);

        // R1 R2 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            vol_code = VEC[i][45:40];
            sample((VEC[i][45:40] > 60) ? "R2 cut" : "R1 R8 vol",
                   int'($signed(VEC[i][39:20])), int'($signed(VEC[i][19:0])));
        end

        // R9 hold between strobes
        vol_code = 6'd3;
        sample("R9 strobe", 20000, -20000);
        begin
            logic [19:0] hl;
            hl = out_l;
            smp_l = 20'sd5;
            repeat (3) @(negedge clk);
            report("R9 no valid", out_valid == 0, int'(out_valid), 0);
            report("R9 hold", out_l == hl, int'($signed(out_l)), int'($signed(hl)));
        end

        // R3 R4 pin mute fade and R6 release
        vol_code = 6'd0;
        mute_pin = 1;
        for (int k = 0; k < 36; k++) sample("R3 R4 pin fade", 400000, -300000);
        mute_pin = 0;
        for (int k = 0; k < 36; k++) sample("R6 release", 400000, -300000);

        // R4 register mute, R7 reversal mid-fade
        mute_bit = 1;
        for (int k = 0; k < 10; k++) sample("R4 bit fade", -450000, 350000);
        mute_bit = 0;
        for (int k = 0; k < 4; k++) sample("R7 reverse up", -450000, 350000);
        mute_bit = 1;
        for (int k = 0; k < 6; k++) sample("R7 reverse down", -450000, 350000);
        mute_bit = 0;
        for (int k = 0; k < 14; k++) sample("R7 settle", -450000, 350000);

        // R5 automatic mute on loss of lock, then override
        vol_code = 6'd2;
        lock_ok = 0;
        for (int k = 0; k < 34; k++) sample("R5 lock mute", 300000, 300000);
        lock_mute_off = 1;
        for (int k = 0; k < 34; k++) sample("R5 override", 300000, 300000);
        lock_ok = 1;
        vol_code = 6'd0;
        sample("R5 R8 full scale", 524287, -524288);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule